// File: doc/BRIEF.md
# Serial Channel Data Register

This block is the per-channel data path of a multi-mode serial unit. It keeps one 16-bit register. The low nine bits act as the shared transmit/receive buffer. The upper seven bits set the bit-rate divider for the operating clock. A 9-bit shift register sits between that buffer and one serial line. It is loaded from the buffer before a transfer, and its contents are copied back into the buffer once the transfer ends. Software never reaches the shift register directly. It sees only the data register, through full 16-bit accesses or 8-bit accesses to the low byte.

Data is always right-aligned at bit 0, whatever the length or line bit order. The length can be 7, 8 or 9 bits. The 9-bit length exists only on the one channel that the `WIDE_CHAN_ID` parameter names. A divider counter produces a bit tick from the upper register field. On each tick, while shifting is enabled, one bit leaves on the serial output and one bit enters from the serial input. Framing, parity and protocol control belong to the surrounding logic.

Top module: `ser_chan_data`

## Requirements
- R1: After reset the register reads 0x0000, both done outputs are low and the bit tick is low.
- R2: A write with byte enables 2'b11 stores all 16 bits of write data, and the read port returns the register contents.
- R3: A write with byte enables 2'b01 while the channel is enabled replaces bits 7..0 only; bits 15..8 keep their value.
- R4: A write with byte enables 2'b01 while the channel is disabled replaces bits 7..0, clears bits 15..9 and keeps bit 8.
- R5: Length select 2'b00 gives 7 bits and 2'b01 gives 8 bits. 2'b10 or 2'b11 gives 9 bits when `CHAN_ID` equals `WIDE_CHAN_ID`, and 8 bits on any other channel.
- R6: While enabled, the bit tick is a one-cycle pulse with period 2*(D+1) cycles, where D is register bits 15..9. Disabling restarts the count, so the first tick comes 2*D+1 cycles after enable rises.
- R7: A load request copies the buffer, masked to the active length, into the shift register. `load_done_o` pulses high for exactly the following cycle.
- R8: With LSB-first order (`msb_first_i` = 0), a shift happens on each tick while shifting and the channel are enabled. Buffer bit 0 leaves first, and the first received bit ends in bit 0.
- R9: With MSB-first order, the top bit of the active length leaves first, and the first received bit ends in bit length-1.
- R10: A capture request writes the shift-register contents into bits 8..0 with every bit at or above the active length forced to 0, and leaves bits 15..9 unchanged. `capture_done_o` pulses high for exactly the following cycle.
- R11: A write with byte enables 2'b00 or 2'b10 changes no register bit.
- R12: While the channel is disabled the serial output is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Operating clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_en_i | input | 1 | Channel enable |
| bus_wr_i | input | 1 | Register write strobe |
| bus_be_i | input | 2 | Byte enables: 2'b11 full, 2'b01 low byte |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Register contents |
| len_sel_i | input | 2 | Data length select |
| msb_first_i | input | 1 | Line bit order, 1 = MSB first |
| load_i | input | 1 | Copy buffer into shift register |
| capture_i | input | 1 | Copy shift register into buffer |
| shift_en_i | input | 1 | Allow shifting on bit ticks |
| ser_in_i | input | 1 | Serial input |
| ser_out_o | output | 1 | Serial output |
| bit_tick_o | output | 1 | Bit-rate tick |
| load_done_o | output | 1 | Load completed pulse |
| capture_done_o | output | 1 | Capture completed pulse |

## Verification
Register writes, loads and captures each take effect on the clock edge that samples the request. The new register value and the done pulse can therefore be read one edge later, and the done pulse has gone again one further edge on. The bench drives every request just after a falling edge and reads the result at the next falling edge, which puts exactly one rising edge between stimulus and check. For the tick, the bench counts falling edges from the enable rise and expects the first tick at 2*D+1 and then one every 2*(D+1). In serial frames it reads the output bit at the same falling edge where it sees the tick and presents the next input bit, so each shift lands on the rising edge that follows.

// File: rtl/ser_chan_pkg.sv
package ser_chan_pkg;
  localparam int unsigned BUF_W = 9;
  localparam int unsigned DIV_W = 7;
  localparam int unsigned REG_W = BUF_W + DIV_W;
  localparam int unsigned CNT_W = DIV_W + 1;
  localparam int unsigned LEN_W = 4;

  localparam logic [1:0] BE_FULL = 2'b11;
  localparam logic [1:0] BE_LOW  = 2'b01;

  typedef logic [LEN_W-1:0] len_t;

  function automatic logic [BUF_W-1:0] len_mask(input len_t len);
    logic [BUF_W-1:0] m;
    for (int i = 0; i < BUF_W; i++) m[i] = (i < int'(len));
    return m;
  endfunction
endpackage

// File: rtl/ser_baud_div.sv
module ser_baud_div
  import ser_chan_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim    = {div_i, 1'b1};  // 2*(D+1) - 1
  assign tick_o = en_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!en_i)          cnt_q <= '0;
    else if (cnt_q == lim)   cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);  // R6
  AST_TICK_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !tick_o);  // R6
endmodule

// File: rtl/ser_shift_reg.sv
module ser_shift_reg
  import ser_chan_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  len_t             len_i,
  input  logic             msb_first_i,
  input  logic             load_i,
  input  logic [BUF_W-1:0] load_data_i,
  input  logic             step_i,
  input  logic             sin_i,
  output logic [BUF_W-1:0] sr_o,
  output logic [BUF_W-1:0] mask_o,
  output logic             sout_o,
  output logic             load_done_o
);
  logic [BUF_W-1:0] sr_q, sr_nxt;
  logic [BUF_W:0]   ext;
  len_t             top;

  assign mask_o = len_mask(len_i);
  assign top    = len_i - 1'b1;
  assign ext    = {1'b0, sr_q};
  assign sr_o   = sr_q;
  assign sout_o = !en_i ? 1'b1 : (msb_first_i ? sr_q[top] : sr_q[0]);

  always_comb begin
    if (msb_first_i) begin
      sr_nxt = {sr_q[BUF_W-2:0], sin_i} & mask_o;
    end else begin
      for (int i = 0; i < BUF_W; i++)
        sr_nxt[i] = (i == int'(top)) ? sin_i : (mask_o[i] & ext[i+1]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q        <= '0;
      load_done_o <= 1'b0;
    end else begin
      load_done_o <= load_i;
      if (load_i)      sr_q <= load_data_i & mask_o;
      else if (step_i) sr_q <= sr_nxt;
    end
  end

  AST_LOAD_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> load_done_o && (sr_o == $past(load_data_i & mask_o)));  // R7
  AST_LSB_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !msb_first_i) |=> sr_o[$past(top)] == $past(sin_i));  // R8
  AST_MSB_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && msb_first_i) |=> sr_o[0] == $past(sin_i));  // R9
endmodule

// File: rtl/ser_data_reg.sv
module ser_data_reg
  import ser_chan_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             wr_i,
  input  logic [1:0]       be_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             cap_i,
  input  logic [BUF_W-1:0] cap_data_i,
  input  logic [BUF_W-1:0] cap_mask_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [BUF_W-1:0] buf_o,
  output logic [DIV_W-1:0] div_o
);
  logic [REG_W-1:0] data_q, data_nxt;

  always_comb begin
    data_nxt = data_q;
    if (wr_i && be_i == BE_FULL) begin
      data_nxt = wdata_i;
    end else if (wr_i && be_i == BE_LOW) begin
      data_nxt[7:0] = wdata_i[7:0];
      if (!en_i) data_nxt[REG_W-1:BUF_W] = '0;  // stopped byte write drops divider
    end
    if (cap_i) data_nxt[BUF_W-1:0] = cap_data_i & cap_mask_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else         data_q <= data_nxt;
  end

  assign rdata_o = data_q;
  assign buf_o   = data_q[BUF_W-1:0];
  assign div_o   = data_q[REG_W-1:BUF_W];

  AST_BYTE_WR_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && be_i == BE_LOW && en_i && !cap_i) |=> rdata_o[REG_W-1:8] == $past(rdata_o[REG_W-1:8]));  // R3
  AST_BYTE_WR_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && be_i == BE_LOW && !en_i) |=> rdata_o[REG_W-1:BUF_W] == '0);  // R4
  AST_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && be_i != BE_FULL && be_i != BE_LOW && !cap_i) |=> $stable(rdata_o));  // R11
endmodule

// File: rtl/ser_chan_data.sv
module ser_chan_data
  import ser_chan_pkg::*;
#(
  parameter int unsigned CHAN_ID      = 0,
  parameter int unsigned WIDE_CHAN_ID = 0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        chan_en_i,
  input  logic        bus_wr_i,
  input  logic [1:0]  bus_be_i,
  input  logic [15:0] bus_wdata_i,
  output logic [15:0] bus_rdata_o,
  input  logic [1:0]  len_sel_i,
  input  logic        msb_first_i,
  input  logic        load_i,
  input  logic        capture_i,
  input  logic        shift_en_i,
  input  logic        ser_in_i,
  output logic        ser_out_o,
  output logic        bit_tick_o,
  output logic        load_done_o,
  output logic        capture_done_o
);
  len_t             eff_len, long_len;
  logic [BUF_W-1:0] buf_data, sr_data, mask;
  logic [DIV_W-1:0] div;
  logic             step;
  logic             cap_done_q;

  if (CHAN_ID == WIDE_CHAN_ID) begin : g_wide
    assign long_len = len_t'(BUF_W);
  end else begin : g_narrow
    assign long_len = len_t'(BUF_W - 1);
  end

  always_comb begin
    case (len_sel_i)
      2'b00:   eff_len = len_t'(BUF_W - 2);
      2'b01:   eff_len = len_t'(BUF_W - 1);
      default: eff_len = long_len;
    endcase
  end

  assign step = bit_tick_o && shift_en_i && chan_en_i;

  ser_data_reg u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (chan_en_i),
    .wr_i       (bus_wr_i),
    .be_i       (bus_be_i),
    .wdata_i    (bus_wdata_i),
    .cap_i      (capture_i),
    .cap_data_i (sr_data),
    .cap_mask_i (mask),
    .rdata_o    (bus_rdata_o),
    .buf_o      (buf_data),
    .div_o      (div)
  );

  ser_baud_div u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (chan_en_i),
    .div_i  (div),
    .tick_o (bit_tick_o)
  );

  ser_shift_reg u_sr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (chan_en_i),
    .len_i       (eff_len),
    .msb_first_i (msb_first_i),
    .load_i      (load_i),
    .load_data_i (buf_data),
    .step_i      (step),
    .sin_i       (ser_in_i),
    .sr_o        (sr_data),
    .mask_o      (mask),
    .sout_o      (ser_out_o),
    .load_done_o (load_done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_done_q <= 1'b0;
    else         cap_done_q <= capture_i;
  end
  assign capture_done_o = cap_done_q;

  AST_CAP_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> capture_done_o && ((bus_rdata_o[BUF_W-1:0] & ~$past(mask)) == '0));  // R10
  AST_CAP_KEEPS_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_i && !bus_wr_i) |=> bus_rdata_o[15:BUF_W] == $past(bus_rdata_o[15:BUF_W]));  // R10
  AST_LEN_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_sel_i[1] |-> $countones(mask) == ((CHAN_ID == WIDE_CHAN_ID) ? BUF_W : BUF_W - 1));  // R5
endmodule

// File: tb/ser_chan_data_tb.sv
module ser_chan_data_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, chan_en, wr, msb_first, load, cap, shift_en, ser_in;
  logic [1:0]  be, len_sel;
  logic [15:0] wdata;
  logic [15:0] rdata, rdata_nw;
  logic        ser_out, tick, load_done, cap_done;
  logic        ser_out_nw, tick_nw, load_done_nw, cap_done_nw;

  int checks = 0;
  int fails  = 0;

  ser_chan_data #(.CHAN_ID(0), .WIDE_CHAN_ID(0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .chan_en_i(chan_en), .bus_wr_i(wr), .bus_be_i(be),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .len_sel_i(len_sel), .msb_first_i(msb_first),
    .load_i(load), .capture_i(cap), .shift_en_i(shift_en), .ser_in_i(ser_in),
    .ser_out_o(ser_out), .bit_tick_o(tick), .load_done_o(load_done), .capture_done_o(cap_done)
  );

  ser_chan_data #(.CHAN_ID(1), .WIDE_CHAN_ID(0)) dut_nw_i (
    .clk_i(clk), .rst_ni(rst_n), .chan_en_i(chan_en), .bus_wr_i(wr), .bus_be_i(be),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata_nw), .len_sel_i(len_sel), .msb_first_i(msb_first),
    .load_i(load), .capture_i(cap), .shift_en_i(shift_en), .ser_in_i(ser_in),
    .ser_out_o(ser_out_nw), .bit_tick_o(tick_nw), .load_done_o(load_done_nw),
    .capture_done_o(cap_done_nw)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_wr(input logic [15:0] old, input logic [1:0] b,
                                         input logic [15:0] d, input logic en);
    logic [15:0] r = old;
    if (b == 2'b11) r = d;
    else if (b == 2'b01) begin
      r[7:0] = d[7:0];
      if (!en) r[15:9] = 7'h0;
    end
    return r;
  endfunction

  function automatic int len_of(input logic [1:0] sel, input bit wide);
    if (sel == 2'b00) return 7;
    if (sel == 2'b01) return 8;
    return wide ? 9 : 8;
  endfunction

  // called just after a falling edge; result readable at the next one
  task automatic bus_wr(input logic [1:0] b, input logic [15:0] d);
    wr = 1'b1; be = b; wdata = d;
    @(negedge clk);
    wr = 1'b0; be = 2'b00; wdata = 16'h0;
  endtask

  task automatic measure_ticks(input logic [6:0] dv);
    int p, first, cnt;
    p = 2 * (int'(dv) + 1);
    chan_en = 1'b0;
    bus_wr(2'b11, {dv, 9'h0});
    @(negedge clk);
    chan_en = 1'b1;
    chk("R6 tick at enable", tick, 0);
    first = -1; cnt = 0;
    for (int j = 1; j <= p * 3; j++) begin
      @(negedge clk);
      if (tick) begin
        cnt++;
        if (first < 0) first = j;
      end
    end
    chk("R6 tick count", cnt, 3);
    chk("R6 first tick", first, 2 * int'(dv) + 1);
    chan_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_frame(input logic [1:0] sel, input logic msb, input logic [8:0] v,
                           input logic [8:0] s, input logic [6:0] dv);
    int L, n;
    logic [8:0] txe, txg, rxe;
    L = len_of(sel, 1'b1);
    chan_en = 1'b0; len_sel = sel; msb_first = msb;
    bus_wr(2'b11, {dv, v});
    chan_en = 1'b1;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    chk("R7 load done", load_done, 1);
    @(negedge clk);
    chk("R7 load done pulse end", load_done, 0);
    shift_en = 1'b1; n = 0; txg = '0; txe = '0; rxe = '0;
    while (n < L) begin
      if (tick) begin
        txg[n] = ser_out;
        ser_in = s[n];
        n++;
      end
      @(negedge clk);
    end
    shift_en = 1'b0;
    for (int i = 0; i < L; i++) begin
      txe[i] = msb ? v[L-1-i] : v[i];
      if (msb) rxe[L-1-i] = s[i];
      else     rxe[i] = s[i];
    end
    if (msb) chk("R9 tx order", txg, txe);
    else     chk("R8 tx order", txg, txe);
    cap = 1'b1;
    @(negedge clk);
    cap = 1'b0;
    chk("R10 capture done", cap_done, 1);
    chk(msb ? "R9 rx data" : "R8 rx data", rdata, {dv, rxe});
    chan_en = 1'b0;
    @(negedge clk);
    chk("R10 capture done pulse end", cap_done, 0);
    chk("R12 idle out", ser_out, 1);
  endtask

  logic [15:0] model;

  initial begin
    rst_n = 1'b0; chan_en = 1'b0; wr = 1'b0; be = 2'b00; wdata = 16'h0;
    len_sel = 2'b01; msb_first = 1'b0; load = 1'b0; cap = 1'b0; shift_en = 1'b0; ser_in = 1'b0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset reg", rdata, 16'h0000);
    chk("R1 reset done", {load_done, cap_done}, 0);
    chk("R1 reset tick", tick, 0);
    chk("R12 out disabled", ser_out, 1);

    model = 16'h0;
    for (int k = 0; k < 40; k++) begin
      logic [1:0] b;
      logic [15:0] d;
      logic en;
      b = 2'($urandom_range(0, 3));
      d = 16'($urandom());
      en = 1'($urandom_range(0, 1));
      chan_en = en;
      bus_wr(b, d);
      model = exp_wr(model, b, d, en);
      if (b == 2'b11)      chk("R2 full write", rdata, model);
      else if (b == 2'b01) chk(en ? "R3 byte write run" : "R4 byte write stop", rdata, model);
      else                 chk("R11 ignored write", rdata, model);
    end

    chan_en = 1'b0;
    bus_wr(2'b11, 16'hFFFF);
    chan_en = 1'b1;
    bus_wr(2'b01, 16'h0012);
    chk("R3 byte write keeps high", rdata, 16'hFF12);
    chan_en = 1'b0;
    bus_wr(2'b01, 16'h0034);
    chk("R4 byte write clears divider", rdata, 16'h0134);
    bus_wr(2'b10, 16'hAAAA);
    chk("R11 be 10 ignored", rdata, 16'h0134);
    bus_wr(2'b00, 16'h5555);
    chk("R11 be 00 ignored", rdata, 16'h0134);

    measure_ticks(7'd0);
    measure_ticks(7'd3);
    measure_ticks(7'($urandom_range(1, 12)));

    // length limit per channel: load then capture without shifting
    chan_en = 1'b0;
    bus_wr(2'b11, {7'h05, 9'h1FF});
    len_sel = 2'b10;
    load = 1'b1; @(negedge clk); load = 1'b0;
    cap = 1'b1;  @(negedge clk); cap = 1'b0;
    chk("R5 wide channel 9 bits", rdata, {7'h05, 9'h1FF});
    chk("R5 narrow channel 8 bits", rdata_nw, {7'h05, 9'h0FF});
    bus_wr(2'b11, {7'h05, 9'h1FF});
    len_sel = 2'b00;
    load = 1'b1; @(negedge clk); load = 1'b0;
    cap = 1'b1;  @(negedge clk); cap = 1'b0;
    chk("R5 7-bit length", rdata, {7'h05, 9'h07F});
    chk("R10 high bits cleared", rdata_nw, {7'h05, 9'h07F});

    run_frame(2'b00, 1'b0, 9'h1FF, 9'h055, 7'd0);
    run_frame(2'b10, 1'b1, 9'h101, 9'h0F3, 7'd1);
    run_frame(2'b01, 1'b1, 9'h0A5, 9'h1C3, 7'd2);
    for (int k = 0; k < 30; k++)
      run_frame(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 9'($urandom()),
                9'($urandom()), 7'($urandom_range(0, 3)));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule